// File: doc/BRIEF.md
# Layered LDPC Schedule Sequencer

This controller drives the memory side of a layered quasi-cyclic LDPC decoder. The parity-check matrix is built from 42x42 cyclic permutation blocks, and a codeword spans 16 block columns. A programmable schedule table lists the order in which matrix blocks enter the processing pipeline. Each entry gives a block column, a circulant shift of 0 to 41, and a flag marking the final block of a layer. The sequencer walks the table one entry at a time and issues an LLR read for each entry. A fixed number of cycles later it issues the matching write-back. The processing pipeline, the memories and the syndrome logic are outside this block.

Layers are decoded in sequence, so a block column read by one layer may still be in the pipeline when a later entry reads it again. The sequencer keeps a record of the columns in flight. It holds the next read, raising `stall`, until that column's update has been written. Reordering the table is the only way to reduce stalls. Decoding runs until a fixed iteration limit is reached. It also ends early when `early_term` is high at the moment the final entry of a layer is issued.

States: `S_IDLE` waits for `start` and moves to `S_ISSUE`. `S_ISSUE` issues entries or stalls. It moves to `S_DRAIN` when the iteration limit is reached or when early termination is taken. `S_DRAIN` waits for the pipeline to empty and moves to `S_DONE`. `S_DONE` stays for one cycle and returns to `S_IDLE`.

Top module: `ldpc_layer_sequencer`

## Requirements
- R1: While reset is held and after its release, with no start, rd_en, wr_en, stall and done are 0 and iter_count is 0.
- R2: Reads follow the table in index order, and return to entry 0 after the final entry of each pass. At each read, rd_col, rd_shift and rd_last equal the fields of the entry being issued.
- R3: Every read of column c is followed exactly PIPE_DEPTH cycles later by a one-cycle write with wr_col = c. No write occurs at any other time.
- R4: An entry whose column was read fewer than PIPE_DEPTH+1 cycles earlier is held. stall is 1 on exactly the cycles in which the pending entry is held, and rd_en and stall are never both 1.
- R5: An entry with no column conflict is read in the cycle after the previous read, or in the first cycle after start, with no stall.
- R6: iter_count clears on start and increments when the final table entry is read. After MAX_ITER passes, no further reads occur.
- R7: early_term is sampled only in a cycle that reads an entry whose last flag is 1. If it is 1 then, that read is the final one of the run.
- R8: done is a one-cycle pulse PIPE_DEPTH+2 cycles after the final read, once every write has been issued.
- R9: start has no effect while a run is in progress.
- R10: Entry i sits at seq_table bits [11*i +: 11]. Within an entry, bits [3:0] hold the column, bits [9:4] the shift and bit 10 the last-in-layer flag.
- R11: A read and a write never target the same column in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a decode run (ignored unless idle) |
| early_term | input | 1 | Request to stop, sampled on layer-final reads |
| seq_table | input | 11*SEQ_LEN | Schedule table, entry i at [11*i +: 11] |
| rd_en | output | 1 | LLR read strobe |
| rd_col | output | 4 | Block column to read |
| rd_shift | output | 6 | Circulant shift for the read block |
| rd_last | output | 1 | Read is the final block of its layer |
| wr_en | output | 1 | LLR write-back strobe |
| wr_col | output | 4 | Block column being written |
| stall | output | 1 | Pending read held for a column hazard |
| iter_count | output | $clog2(MAX_ITER+1) | Completed passes over the table |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The assertions assume that `seq_table` stays constant during a run, that `start` and `early_term` change only away from the clock edge, and that every shift field is at most 41. The bench writes each table before it raises `start` and keeps it unchanged until `done`. It drives all inputs on the falling edge and uses only shifts in the legal range, including 41. Expected read cycles come from a simple spacing rule: each read comes at least one cycle after the previous read and at least PIPE_DEPTH+1 cycles after the last read of the same column. Write, stall and done cycles follow from that rule.

// File: rtl/ldpc_seq_pkg.sv
package ldpc_seq_pkg;
    localparam int COL_W   = 4;
    localparam int SHIFT_W = 6;
    localparam int ENTRY_W = COL_W + SHIFT_W + 1;

    typedef struct packed {
        logic               last;
        logic [SHIFT_W-1:0] shift;
        logic [COL_W-1:0]   col;
    } seq_entry_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_DRAIN,
        S_DONE
    } seq_state_t;
endpackage

// File: rtl/seq_entry_sel.sv
module seq_entry_sel
    import ldpc_seq_pkg::*;
#(
    parameter int SEQ_LEN = 8,
    parameter int PTR_W   = 3
) (
    input  logic [SEQ_LEN*ENTRY_W-1:0] table_i,
    input  logic [PTR_W-1:0]           ptr_i,
    output seq_entry_t                 entry_o
);
    seq_entry_t slots [SEQ_LEN];

    for (genvar g = 0; g < SEQ_LEN; g++) begin : g_unpack
        assign slots[g] = table_i[g*ENTRY_W +: ENTRY_W];
    end

    always_comb begin
        entry_o = '0;
        for (int i = 0; i < SEQ_LEN; i++) begin
            if (ptr_i == PTR_W'(i)) entry_o = slots[i];
        end
    end
endmodule

// File: rtl/inflight_board.sv
module inflight_board #(
    parameter int DEPTH = 4,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [CW-1:0] push_col_i,
    input  logic [CW-1:0] probe_col_i,
    output logic          hit_o,
    output logic          wb_en_o,
    output logic [CW-1:0] wb_col_o,
    output logic          empty_o
);
    logic [DEPTH-1:0] vld_q;
    logic [CW-1:0]    col_q [DEPTH];
    logic [DEPTH-1:0] match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int k = 0; k < DEPTH; k++) col_q[k] <= '0;
        end else begin
            vld_q[0] <= push_i;
            col_q[0] <= push_col_i;
            for (int k = 1; k < DEPTH; k++) begin
                vld_q[k] <= vld_q[k-1];
                col_q[k] <= col_q[k-1];
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (col_q[g] == probe_col_i);
    end

    assign hit_o    = |match;
    assign wb_en_o  = vld_q[DEPTH-1];
    assign wb_col_o = col_q[DEPTH-1];
    assign empty_o  = ~|vld_q;
endmodule

// File: rtl/pass_counter.sv
module pass_counter #(
    parameter int LIMIT = 5,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          bump_i,
    output logic [CW-1:0] count_o,
    output logic          final_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)       count_o <= '0;
        else if (clear_i) count_o <= '0;
        else if (bump_i)  count_o <= count_o + 1'b1;
    end

    assign final_o = (count_o == CW'(LIMIT - 1));
endmodule

// File: rtl/ldpc_layer_sequencer.sv
module ldpc_layer_sequencer
    import ldpc_seq_pkg::*;
#(
    parameter int SEQ_LEN    = 8,
    parameter int PIPE_DEPTH = 4,
    parameter int MAX_ITER   = 5
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start,
    input  logic                                 early_term,
    input  logic [SEQ_LEN*ENTRY_W-1:0]           seq_table,
    output logic                                 rd_en,
    output logic [COL_W-1:0]                     rd_col,
    output logic [SHIFT_W-1:0]                   rd_shift,
    output logic                                 rd_last,
    output logic                                 wr_en,
    output logic [COL_W-1:0]                     wr_col,
    output logic                                 stall,
    output logic [$clog2(MAX_ITER+1)-1:0]        iter_count,
    output logic                                 done
);
    localparam int PTR_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
    localparam int IT_W  = $clog2(MAX_ITER + 1);

    seq_state_t       state_q, state_d;
    logic [PTR_W-1:0] ptr_q;
    seq_entry_t       cur;
    logic             hit, pipe_empty, last_pass;
    logic             issue, seq_end, stop_now, launch;

    seq_entry_sel #(.SEQ_LEN(SEQ_LEN), .PTR_W(PTR_W)) u_sel (
        .table_i (seq_table),
        .ptr_i   (ptr_q),
        .entry_o (cur)
    );

    inflight_board #(.DEPTH(PIPE_DEPTH), .CW(COL_W)) u_board (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (issue),
        .push_col_i  (cur.col),
        .probe_col_i (cur.col),
        .hit_o       (hit),
        .wb_en_o     (wr_en),
        .wb_col_o    (wr_col),
        .empty_o     (pipe_empty)
    );

    pass_counter #(.LIMIT(MAX_ITER), .CW(IT_W)) u_pass (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (launch),
        .bump_i  (issue && seq_end),
        .count_o (iter_count),
        .final_o (last_pass)
    );

    assign launch   = (state_q == S_IDLE) && start;
    assign issue    = (state_q == S_ISSUE) && !hit;
    assign seq_end  = (ptr_q == PTR_W'(SEQ_LEN - 1));
    assign stop_now = issue && ((cur.last && early_term) || (seq_end && last_pass));

    // state register and table pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (launch)     ptr_q <= '0;
            else if (issue) ptr_q <= seq_end ? '0 : ptr_q + 1'b1;
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start)      state_d = S_ISSUE;
            S_ISSUE: if (stop_now)   state_d = S_DRAIN;
            S_DRAIN: if (pipe_empty) state_d = S_DONE;
            S_DONE:                  state_d = S_IDLE;
            default:                 state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_en    = issue;
        rd_col   = issue ? cur.col   : '0;
        rd_shift = issue ? cur.shift : '0;
        rd_last  = issue && cur.last;
        stall    = (state_q == S_ISSUE) && hit;
        done     = (state_q == S_DONE);
    end
endmodule

// File: rtl/ldpc_layer_sequencer_chk.sv
module ldpc_layer_sequencer_chk #(
    parameter int PIPE_DEPTH = 4,
    parameter int MAX_ITER   = 5,
    parameter int IT_W       = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rd_en,
    input logic [3:0]      rd_col,
    input logic            wr_en,
    input logic [3:0]      wr_col,
    input logic            stall,
    input logic            done,
    input logic [IT_W-1:0] iter_count
);
    logic [PIPE_DEPTH-1:0] dly_v;
    logic [3:0]            dly_c [PIPE_DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_v <= '0;
            for (int k = 0; k < PIPE_DEPTH; k++) dly_c[k] <= '0;
        end else begin
            dly_v[0] <= rd_en;
            dly_c[0] <= rd_col;
            for (int k = 1; k < PIPE_DEPTH; k++) begin
                dly_v[k] <= dly_v[k-1];
                dly_c[k] <= dly_c[k-1];
            end
        end
    end

    assert_wr_after_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dly_v[PIPE_DEPTH-1] |-> (wr_en && wr_col == dly_c[PIPE_DEPTH-1]));
    assert_no_stray_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> dly_v[PIPE_DEPTH-1]);
    assert_rd_stall_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && stall));
    assert_iter_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        iter_count <= IT_W'(MAX_ITER));
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rd_en && !wr_en && !stall));
    assert_rw_col_apart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |-> (rd_col != wr_col));
endmodule

bind ldpc_layer_sequencer ldpc_layer_sequencer_chk #(
    .PIPE_DEPTH (PIPE_DEPTH),
    .MAX_ITER   (MAX_ITER),
    .IT_W       ($clog2(MAX_ITER + 1))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_col     (rd_col),
    .wr_en      (wr_en),
    .wr_col     (wr_col),
    .stall      (stall),
    .done       (done),
    .iter_count (iter_count)
);

// File: tb/tb_ldpc_layer_sequencer.sv
module tb_ldpc_layer_sequencer;
    localparam int SEQ_LEN = 8;
    localparam int P       = 4;
    localparam int MAXIT   = 5;
    localparam int EW      = 11;
    localparam int ITW     = $clog2(MAXIT + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic early_term = 1'b0;
    logic [SEQ_LEN*EW-1:0] seq_table = '0;
    logic rd_en, rd_last, wr_en, stall, done;
    logic [3:0] rd_col, wr_col;
    logic [5:0] rd_shift;
    logic [ITW-1:0] iter_count;

    int total = 0;
    int bad = 0;

    int tcol [SEQ_LEN];
    int tsh  [SEQ_LEN];
    int tlst [SEQ_LEN];

    int exp_t   [64];
    int exp_idx [64];
    int n_exp;
    int exp_iter;

    always #4 clk = ~clk;

    ldpc_layer_sequencer #(.SEQ_LEN(SEQ_LEN), .PIPE_DEPTH(P), .MAX_ITER(MAXIT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .early_term(early_term),
        .seq_table(seq_table), .rd_en(rd_en), .rd_col(rd_col), .rd_shift(rd_shift),
        .rd_last(rd_last), .wr_en(wr_en), .wr_col(wr_col), .stall(stall),
        .iter_count(iter_count), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expv);
        end
    endtask

    // R10 encoding: col [3:0], shift [9:4], last [10], entry i at [11*i +: 11]
    task automatic load_table();
        for (int i = 0; i < SEQ_LEN; i++) begin
            seq_table[i*EW +: EW] = {tlst[i][0], 6'(tsh[i]), 4'(tcol[i])};
        end
    endtask

    task automatic predict(input bit early);
        int lastrd [16];
        int prev;
        bit stop;
        for (int c = 0; c < 16; c++) lastrd[c] = -100;
        prev = -1; n_exp = 0; exp_iter = 0; stop = 0;
        for (int it = 0; it < MAXIT && !stop; it++) begin
            for (int i = 0; i < SEQ_LEN && !stop; i++) begin
                int t;
                t = prev + 1;
                if (lastrd[tcol[i]] + P + 1 > t) t = lastrd[tcol[i]] + P + 1;
                exp_t[n_exp] = t; exp_idx[n_exp] = i; n_exp++;
                lastrd[tcol[i]] = t; prev = t;
                if (i == SEQ_LEN - 1) exp_iter++;
                if (early && tlst[i] != 0) stop = 1;
            end
        end
    endtask

    task automatic run_case(input string name, input bit early, input bit glitch);
        int rn, tl, nreads;
        predict(early);
        load_table();
        tl = exp_t[n_exp-1];
        early_term = early;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        rn = 0; nreads = 0;
        for (int k = 0; k <= tl + P + 3; k++) begin
            bit er, es, ew, ed;
            int wi;
            er = (rn < n_exp) && (exp_t[rn] == k);
            es = (rn < n_exp) && !er;
            ew = 0; wi = 0;
            for (int j = 0; j < n_exp; j++) if (exp_t[j] == k - P) begin ew = 1; wi = j; end
            ed = (k == tl + P + 2);
            chk(rd_en == er, "R4 R5", {name, " rd_en"}, int'(rd_en), int'(er));
            chk(stall == es, "R4", {name, " stall"}, int'(stall), int'(es));
            if (er && rd_en) begin
                int e;
                e = exp_idx[rn];
                chk(rd_col == 4'(tcol[e]), "R2 R10", {name, " rd_col"}, int'(rd_col), tcol[e]);
                chk(rd_shift == 6'(tsh[e]), "R2 R10", {name, " rd_shift"}, int'(rd_shift), tsh[e]);
                chk(rd_last == tlst[e][0], "R2", {name, " rd_last"}, int'(rd_last), tlst[e]);
            end
            chk(wr_en == ew, "R3", {name, " wr_en"}, int'(wr_en), int'(ew));
            if (ew && wr_en)
                chk(wr_col == 4'(tcol[exp_idx[wi]]), "R3", {name, " wr_col"},
                    int'(wr_col), tcol[exp_idx[wi]]);
            if (rd_en && wr_en)
                chk(rd_col != wr_col, "R11", {name, " rd/wr same col"}, int'(rd_col), -1);
            chk(done == ed, "R8", {name, " done"}, int'(done), int'(ed));
            if (rd_en) nreads++;
            if (er) rn++;
            if (glitch) start = (k == 2 || k == 5);
            @(negedge clk);
        end
        start = 1'b0;
        chk(nreads == n_exp, early ? "R7" : (glitch ? "R9" : "R6"), {name, " read count"},
            nreads, n_exp);
        chk(int'(iter_count) == exp_iter, "R6", {name, " iter_count"}, int'(iter_count), exp_iter);
        repeat (3) begin
            chk(!rd_en && !stall && !done, "R9", {name, " idle after run"},
                int'({rd_en, stall, done}), 0);
            @(negedge clk);
        end
        early_term = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < SEQ_LEN; i++) begin tcol[i] = i; tsh[i] = 0; tlst[i] = 0; end
        load_table();
        repeat (3) @(negedge clk);
        chk(!rd_en && !wr_en && !stall && !done, "R1", "outputs in reset",
            int'({rd_en, wr_en, stall, done}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!rd_en && !wr_en && !stall && !done, "R1", "outputs after reset",
            int'({rd_en, wr_en, stall, done}), 0);
        chk(iter_count == 0, "R1", "iter_count after reset", int'(iter_count), 0);

        // distinct columns, no hazards; start pulsed mid-run (R9)
        for (int i = 0; i < SEQ_LEN; i++) begin
            tcol[i] = i; tsh[i] = (i * 5) % 42; tlst[i] = (i % 4 == 3);
        end
        run_case("distinct", 1'b0, 1'b1);

        // repeated columns forcing stalls
        tcol = '{1, 1, 2, 1, 3, 2, 3, 3};
        tsh  = '{0, 41, 7, 13, 20, 33, 2, 41};
        tlst = '{0, 0, 1, 0, 0, 0, 0, 1};
        run_case("hazard", 1'b0, 1'b0);

        // extreme columns and shifts
        tcol = '{15, 0, 15, 0, 14, 15, 0, 9};
        tsh  = '{41, 0, 41, 1, 40, 41, 0, 21};
        tlst = '{0, 1, 0, 1, 0, 0, 1, 1};
        run_case("edges", 1'b0, 1'b0);

        // early stop at first layer boundary
        tcol = '{4, 5, 6, 7, 8, 9, 10, 11};
        tsh  = '{1, 2, 3, 4, 5, 6, 7, 8};
        tlst = '{0, 0, 0, 1, 0, 0, 0, 1};
        run_case("early_mid", 1'b1, 1'b0);

        // early stop only at sequence end: one full pass
        tcol = '{2, 2, 3, 4, 2, 5, 6, 2};
        tsh  = '{9, 8, 7, 6, 5, 4, 3, 41};
        tlst = '{0, 0, 0, 0, 0, 0, 0, 1};
        run_case("early_end", 1'b1, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule